// File: doc/BRIEF.md
# Serial 01101 Pattern Spotter

This block watches a single serial data line, one bit per clock, and raises a one-cycle pulse on its output in the same cycle in which the bit that completes the pattern 0, 1, 1, 0, 1 (oldest first) is at its input. Matches may share bits. After a hit, the trailing "01" of the pattern already counts as the start of the next occurrence. For example, the stream 0101101101 gives the pulses 0000001001, bit for bit.

The matching is done by an explicit prefix-tracking state machine, not by a shift-register compare. The machine has six states: empty prefix, "0", "01", "011", "0110", and a matched state that behaves exactly like "01". The pulse is a Mealy output, formed from the current state and the live input bit. The state register can be built either from toggle flip-flops or from plain storage flops. A parameter selects between them, and the behaviour at the ports is the same for both.

Top module: `serial_motif_detector`

## Requirements
- R1: A synchronous active-high reset forces `hit` to 0 in every cycle where `rst` is 1. The reset returns the machine to the empty prefix, so the first bit sampled after reset starts a fresh search.
- R2: `hit` is 1 in the cycle in which `din` carries a 1 that ends the bit run 0,1,1,0,1 (oldest first). That run is the four bits sampled at the previous four clock edges since reset, followed by the current `din`.
- R3: In every other cycle `hit` is 0, including the first four bits after reset.
- R4: Overlapping occurrences are detected. After a hit, the machine continues from the "01" prefix, so the input 0101101101 yields the output 0000001001.
- R5: A 0 received when the seen prefix is "0110" falls back to the "0" prefix. The input 1011001101 yields 0000000001.
- R6: A 1 received when the seen prefix is "011" falls back to the empty prefix. The input 0111011011 yields 0000000010.
- R7: A 1 received at the empty prefix leaves the machine at the empty prefix. The input 1111101101 yields 0000000001.
- R8: `hit` is never 1 in two consecutive cycles.
- R9: The toggle-flop register variant (USE_TFF=1) and the plain-storage variant (USE_TFF=0) produce identical `hit` sequences for any input and reset stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state advances on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Serial data bit, sampled on each rising edge |
| hit | output | 1 | Pulse, high in the cycle the completing bit is present |

## Verification
Two functions can fall in the same cycle: reporting a completed pattern and re-seeding the "01" prefix for the next one. The stream 0101101101 provokes this, and the bench judges it by requiring a second pulse exactly three bits after the first. A second collision is a reset arriving while the machine sits at "0110" with a 1 on `din`. Here the reset must win: the bench checks that `hit` stays low in that cycle and that a later 1 does not complete a stale prefix. Long random streams are compared against a five-bit sliding-window model, and the two register variants are compared against each other.

// File: rtl/mdet_pkg.sv
package mdet_pkg;

  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_NONE  = 3'd0,
    ST_P0    = 3'd1,
    ST_P01   = 3'd2,
    ST_P011  = 3'd3,
    ST_P0110 = 3'd4,
    ST_MATCH = 3'd5
  } mdet_state_e;

  // Prefix progress after one more bit.
  function automatic mdet_state_e step_state(mdet_state_e s, logic b);
    mdet_state_e n;
    case (s)
      ST_NONE:  n = b ? ST_NONE  : ST_P0;
      ST_P0:    n = b ? ST_P01   : ST_P0;
      ST_P01:   n = b ? ST_P011  : ST_P0;
      ST_P011:  n = b ? ST_NONE  : ST_P0110;
      ST_P0110: n = b ? ST_MATCH : ST_P0;
      ST_MATCH: n = b ? ST_P011  : ST_P0;
      default:  n = ST_NONE;
    endcase
    return n;
  endfunction

  // Completion of the pattern by the live bit.
  function automatic logic completes(mdet_state_e s, logic b);
    return (s == ST_P0110) && b;
  endfunction

endpackage

// File: rtl/mdet_next.sv
module mdet_next
  import mdet_pkg::*;
(
  input  mdet_state_e cur,
  input  logic        bit_in,
  output mdet_state_e nxt,
  output logic        done
);

  always_comb begin
    nxt  = step_state(cur, bit_in);
    done = completes(cur, bit_in);
  end

endmodule

// File: rtl/mdet_state_reg.sv
module mdet_state_reg #(
  parameter int                W       = 3,
  parameter logic [W-1:0]      RST_VAL = '0,
  parameter bit                USE_TFF = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (USE_TFF) begin : g_toggle
      logic [W-1:0] tq;
      logic [W-1:0] tgl;
      assign tgl = tq ^ d;
      always_ff @(posedge clk) begin
        if (rst) tq <= RST_VAL;
        else     tq <= tq ^ tgl;
      end
      assign q = tq;
    end else begin : g_direct
      logic [W-1:0] dq;
      always_ff @(posedge clk) begin
        if (rst) dq <= RST_VAL;
        else     dq <= d;
      end
      assign q = dq;
    end
  endgenerate

endmodule

// File: rtl/serial_motif_detector.sv
module serial_motif_detector
  import mdet_pkg::*;
#(
  parameter bit USE_TFF = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic hit
);

  mdet_state_e                 state_q;
  mdet_state_e                 state_d;
  logic [STATE_W-1:0]          state_bits;
  logic                        match_evt;

  mdet_next u_next (
    .cur    (state_q),
    .bit_in (din),
    .nxt    (state_d),
    .done   (match_evt)
  );

  mdet_state_reg #(
    .W       (STATE_W),
    .RST_VAL (ST_NONE),
    .USE_TFF (USE_TFF)
  ) u_sreg (
    .clk (clk),
    .rst (rst),
    .d   (state_d),
    .q   (state_bits)
  );

  assign state_q = mdet_state_e'(state_bits);

  // Reset has priority over a completion in the same cycle.
  assign hit = match_evt & ~rst;

endmodule

// File: rtl/mdet_checker.sv
module mdet_checker
  import mdet_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               din,
  input logic               hit,
  input logic               match_evt,
  input logic [STATE_W-1:0] state_q
);

  logic [3:0] hist;
  logic [2:0] seen;
  logic       window_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= '0;
      seen <= '0;
    end else begin
      hist <= {hist[2:0], din};
      if (seen != 3'd4) seen <= seen + 3'd1;
    end
  end

  assign window_ok = (seen == 3'd4) && (hist == 4'b0110) && din;

  assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (state_q == ST_NONE));

  assert_quiet_in_reset_R1: assert property (@(posedge clk)
    rst |-> !hit);

  assert_window_fires_R2: assert property (@(posedge clk) disable iff (rst)
    window_ok |-> hit);

  assert_hit_needs_window_R3: assert property (@(posedge clk) disable iff (rst)
    hit |-> window_ok);

  assert_resume_at_01_R4: assert property (@(posedge clk) disable iff (rst)
    hit |=> (state_q == ST_MATCH));

  assert_fallback_0_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_P0110 && !din) |=> (state_q == ST_P0));

  assert_fallback_none_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_P011 && din) |=> (state_q == ST_NONE));

  assert_ones_hold_none_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_NONE && din) |=> (state_q == ST_NONE));

  assert_no_back_to_back_R8: assert property (@(posedge clk) disable iff (rst)
    hit |=> !hit);

  assert_legal_state_R3: assert property (@(posedge clk) disable iff (rst)
    state_q <= ST_MATCH);

  assert_evt_vs_pin_R3: assert property (@(posedge clk) disable iff (rst)
    match_evt |-> hit);

endmodule

bind serial_motif_detector mdet_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .din       (din),
  .hit       (hit),
  .match_evt (match_evt),
  .state_q   (state_q)
);

// File: tb/serial_motif_detector_bench.sv
module serial_motif_detector_bench;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1;
  logic din = 1'b0;
  logic hit_t, hit_d;

  serial_motif_detector #(.USE_TFF(1'b1)) u_serial_motif_detector (
    .clk(clk), .rst(rst), .din(din), .hit(hit_t));

  serial_motif_detector #(.USE_TFF(1'b0)) u_serial_motif_detector_d (
    .clk(clk), .rst(rst), .din(din), .hit(hit_d));

  int total = 0;
  int bad   = 0;
  logic [3:0] rhist = '0;
  int         rcnt  = 0;

  localparam logic [9:0] TV_IN  [4] = '{10'b0101101101, 10'b1011001101,
                                        10'b0111011011, 10'b1111101101};
  localparam logic [9:0] TV_OUT [4] = '{10'b0000001001, 10'b0000000001,
                                        10'b0000000010, 10'b0000000001};

  function automatic string tag_of(int v);
    case (v)
      0:       return "R4 R2";
      1:       return "R5";
      2:       return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic ref_hit(input logic r, input logic b);
    return !r && (rcnt >= 4) && (rhist == 4'b0110) && b;
  endfunction

  // Drive one cycle, sample the Mealy output before the edge, advance model.
  task automatic apply(input logic r, input logic b,
                       output logic got_t, output logic got_d, output logic exp);
    @(negedge clk);
    rst = r;
    din = b;
    #1;
    got_t = hit_t;
    got_d = hit_d;
    exp   = ref_hit(r, b);
    if (r) begin
      rcnt  = 0;
      rhist = '0;
    end else begin
      rhist = {rhist[2:0], b};
      if (rcnt < 4) rcnt++;
    end
  endtask

  initial begin
    #800000;
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic gt, gd, ex, prev;

    // R1: reset state, with a 1 on din during reset
    apply(1'b1, 1'b1, gt, gd, ex);
    check(gt, 1'b0, "R1 reset hit");
    apply(1'b1, 1'b0, gt, gd, ex);
    check(gt, 1'b0, "R1 reset hit");

    // Vector table
    for (int v = 0; v < 4; v++) begin
      apply(1'b1, 1'b0, gt, gd, ex);
      for (int i = 9; i >= 0; i--) begin
        apply(1'b0, TV_IN[v][i], gt, gd, ex);
        check(gt, TV_OUT[v][i], tag_of(v));
        check(gd, TV_OUT[v][i], "R9");
      end
    end

    // R1: reset collides with a completing bit, then stale prefix is gone
    apply(1'b1, 1'b0, gt, gd, ex);
    apply(1'b0, 1'b0, gt, gd, ex);
    apply(1'b0, 1'b1, gt, gd, ex);
    apply(1'b0, 1'b1, gt, gd, ex);
    apply(1'b0, 1'b0, gt, gd, ex);
    apply(1'b1, 1'b1, gt, gd, ex);
    check(gt, 1'b0, "R1 reset over completion");
    apply(1'b0, 1'b1, gt, gd, ex);
    check(gt, 1'b0, "R1 no stale prefix");
    apply(1'b0, 1'b0, gt, gd, ex);
    apply(1'b0, 1'b1, gt, gd, ex);
    apply(1'b0, 1'b1, gt, gd, ex);
    apply(1'b0, 1'b0, gt, gd, ex);
    check(gt, 1'b0, "R3 partial");
    apply(1'b0, 1'b1, gt, gd, ex);
    check(gt, 1'b1, "R2 after reset");

    // R3: first four bits after reset never fire
    apply(1'b1, 1'b0, gt, gd, ex);
    for (int i = 0; i < 4; i++) begin
      apply(1'b0, (i == 1 || i == 2), gt, gd, ex);
      check(gt, 1'b0, "R3 warmup");
    end

    // Random streams against the sliding-window model
    prev = 1'b0;
    for (int n = 0; n < 4000; n++) begin
      logic r, b;
      r = (($urandom % 300) == 0);
      b = ($urandom % 3) != 0 ? (($urandom % 2) == 1) : 1'b0;
      apply(r, b, gt, gd, ex);
      check(gt, ex, "R3 random");
      check(gd, gt, "R9 random");
      if (prev && gt) check(gt, 1'b0, "R8");
      prev = gt;
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule